// File: doc/BRIEF.md
# SCL Low-Hold Timeout Detector

This block supervises the clock line of a two-wire serial bus while the local controller acts as bus master. Whenever a slave device holds SCL low during a master transfer, the block counts SCL-rate ticks for as long as the low level lasts. When the hold grows past a programmable limit, the block emits a single-cycle pulse. The interrupt unit uses this pulse to set its timeout status flag.

The limit is held in an 8-bit read/write register. The register value gives the allowed hold in SCL periods minus one. The reset value is 0x1F, and the recommended setting is the maximum, 0xFF.

The limit register is sampled once, on the first cycle of each low period. Writes made during a hold therefore take effect from the next low period onward. The counter advances only on cycles where the tick enable is asserted. It clears as soon as SCL is seen high or master mode drops.

Top module: `scl_to_detector`

## Requirements
- R1: After reset, `limit_rdata_o` reads 0x1F and `timeout_o` is low.
- R2: A cycle with `limit_we_i` high loads `limit_wdata_i` into the limit register, and `limit_rdata_o` shows the new value from the next cycle.
- R3: A qualifying tick is a cycle with `tick_i`=1, `scl_i`=0 and `master_i`=1. With a limit of L, `timeout_o` is high for exactly one cycle, in the cycle after the clock edge that samples the (L+1)-th qualifying tick of a continuous low period.
- R4: Cycles within a low period where `tick_i`=0 do not advance the count, so gaps between ticks do not change which tick raises the pulse.
- R5: A cycle with `scl_i`=1 ends the low period and clears the count. The next low period counts again from zero.
- R6: While `master_i`=0, no tick counts and `timeout_o` stays low. A drop of `master_i` also clears the count.
- R7: At most one pulse is raised per low period, however long SCL stays low. A later low period can pulse again.
- R8: The limit in force for a low period is the register value on the first cycle of that period. A write made during the period leaves the current threshold unchanged and applies from the next period.
- R9: The limit extremes behave as stated. A limit of 0x00 pulses on the first qualifying tick. A limit of 0xFF pulses on the 256th qualifying tick and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled SCL level |
| tick_i | input | 1 | One-cycle enable at the SCL period rate |
| master_i | input | 1 | High while the controller runs a master transfer |
| limit_we_i | input | 1 | Write strobe for the limit register |
| limit_wdata_i | input | 8 | Write data for the limit register |
| limit_rdata_o | output | 8 | Current value of the limit register |
| timeout_o | output | 1 | One-cycle timeout event toward the interrupt unit |

## Verification
The checker assumes the following about the inputs:
- `scl_i` is already synchronised to `clk_i`.
- `tick_i` is a plain one-cycle strobe with no meaning outside SCL-low cycles.
- Any level is legal on every input in every cycle.

Its properties rely only on these port relations: a pulse follows a qualifying tick, a pulse lasts one cycle, and a pulse does not repeat within a low period as tracked by the checker itself.

The directed stimulus meets these assumptions as follows:
- It changes inputs only on the falling clock edge.
- It keeps the limit small except in the dedicated 0xFF case.
- It always ends a low period with SCL high for at least two cycles, so period boundaries in the checker and in the expected values line up.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;
  localparam int unsigned LIM_W_DEF   = 8;
  localparam int unsigned LIM_RST_DEF = 32'h1F;
endpackage

// File: rtl/scl_to_limit_reg.sv
module scl_to_limit_reg #(
  parameter int unsigned LIM_W   = scl_to_pkg::LIM_W_DEF,
  parameter int unsigned LIM_RST = scl_to_pkg::LIM_RST_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LIM_W-1:0] wdata_i,
  output logic [LIM_W-1:0] q_o
);
  localparam logic [LIM_W-1:0] RST_V = LIM_W'(LIM_RST);

  logic [LIM_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_V;
    else if (we_i) q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/scl_to_period_track.sv
// Tracks slave-held low periods and freezes the limit at period start.
module scl_to_period_track #(
  parameter int unsigned LIM_W = scl_to_pkg::LIM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             master_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             qual_o,
  output logic [LIM_W-1:0] eff_lim_o
);
  logic             active_q;
  logic             start;
  logic [LIM_W-1:0] snap_q;

  assign qual_o = !scl_i && master_i;
  assign start  = qual_o && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      active_q <= qual_o;
      if (start) snap_q <= limit_i;
    end
  end

  // first cycle uses the live register, later cycles the frozen copy
  assign eff_lim_o = start ? limit_i : snap_q;
endmodule

// File: rtl/scl_to_tick_counter.sv
module scl_to_tick_counter #(
  parameter int unsigned LIM_W = scl_to_pkg::LIM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] eff_lim_i,
  output logic             timeout_o
);
  localparam int unsigned CNT_W = LIM_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] thresh;
  logic             fired_q;
  logic             adv;
  logic             hit;
  logic             pulse_q;

  assign adv     = qual_i && tick_i && !fired_q;
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign thresh  = {1'b0, eff_lim_i} + CNT_W'(1);
  assign hit     = adv && (cnt_nxt == thresh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (!qual_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (adv) cnt_q <= cnt_nxt;
        if (hit) fired_q <= 1'b1;
      end
    end
  end

  assign timeout_o = pulse_q;
endmodule

// File: rtl/scl_to_detector.sv
module scl_to_detector #(
  parameter int unsigned LIM_W   = scl_to_pkg::LIM_W_DEF,
  parameter int unsigned LIM_RST = scl_to_pkg::LIM_RST_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             tick_i,
  input  logic             master_i,
  input  logic             limit_we_i,
  input  logic [LIM_W-1:0] limit_wdata_i,
  output logic [LIM_W-1:0] limit_rdata_o,
  output logic             timeout_o
);
  logic [LIM_W-1:0] limit_q;
  logic [LIM_W-1:0] eff_lim;
  logic             qual;

  scl_to_limit_reg #(.LIM_W(LIM_W), .LIM_RST(LIM_RST)) u_limit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (limit_we_i),
    .wdata_i (limit_wdata_i),
    .q_o     (limit_q)
  );

  scl_to_period_track #(.LIM_W(LIM_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .master_i  (master_i),
    .limit_i   (limit_q),
    .qual_o    (qual),
    .eff_lim_o (eff_lim)
  );

  scl_to_tick_counter #(.LIM_W(LIM_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .qual_i    (qual),
    .tick_i    (tick_i),
    .eff_lim_i (eff_lim),
    .timeout_o (timeout_o)
  );

  assign limit_rdata_o = limit_q;
endmodule

// File: rtl/scl_to_detector_chk.sv
module scl_to_detector_chk #(
  parameter int unsigned LIM_W = scl_to_pkg::LIM_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             tick_i,
  input logic             master_i,
  input logic             limit_we_i,
  input logic [LIM_W-1:0] limit_wdata_i,
  input logic [LIM_W-1:0] limit_rdata_o,
  input logic             timeout_o
);
  // checker's own record of a pulse within the current low period
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= 1'b0;
    else if (scl_i || !master_i) seen_q <= 1'b0;
    else if (timeout_o)          seen_q <= 1'b1;
  end

  a_r2_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_we_i |=> limit_rdata_o == $past(limit_wdata_i));

  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r4_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(tick_i) && !$past(scl_i));

  a_r6_master_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(master_i));

  a_r7_once_per_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !seen_q);
endmodule

bind scl_to_detector scl_to_detector_chk #(.LIM_W(LIM_W)) u_chk (.*);

// File: tb/scl_to_detector_tb.sv
`timescale 1ns/1ps
module scl_to_detector_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       master_i = 1'b0;
  logic       limit_we_i = 1'b0;
  logic [7:0] limit_wdata_i = '0;
  logic [7:0] limit_rdata_o;
  logic       timeout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  scl_to_detector u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // at negedge on entry and exit
  task automatic wr_limit(input logic [7:0] v);
    limit_we_i = 1'b1; limit_wdata_i = v; tick_i = 1'b0;
    @(negedge clk_i);
    limit_we_i = 1'b0;
  endtask

  task automatic release_scl(input int n);
    scl_i = 1'b1; tick_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // n ticks with gap idle cycles after each; returns pulse count and tick index of first pulse
  task automatic low_run(input int n, input int gap, output int pulses, output int first);
    pulses = 0; first = 0;
    scl_i = 1'b0;
    for (int i = 1; i <= n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      if (timeout_o) begin pulses++; if (first == 0) first = i; end
      tick_i = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_i);
        if (timeout_o) pulses++;
      end
    end
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 limit", limit_rdata_o, 8'h1F);
    check("R1 timeout", timeout_o, 0);
  endtask

  task automatic t_write();
    wr_limit(8'h5A);
    check("R2 readback", limit_rdata_o, 8'h5A);
    wr_limit(8'hA5);
    check("R2 readback2", limit_rdata_o, 8'hA5);
  endtask

  task automatic t_basic();
    int p, f;
    master_i = 1'b1;
    wr_limit(8'd3);
    low_run(10, 0, p, f);
    check("R3 pulse tick", f, 4);
    check("R7 single pulse", p, 1);
    release_scl(2);
    low_run(6, 0, p, f);
    check("R7 refire next period", f, 4);
    release_scl(2);
  endtask

  task automatic t_gaps();
    int p, f;
    low_run(6, 2, p, f);
    check("R4 gapped pulse tick", f, 4);
    check("R4 gapped count", p, 1);
    release_scl(2);
  endtask

  task automatic t_scl_high_clears();
    int p, f, p2, f2;
    wr_limit(8'd5);
    low_run(4, 0, p, f);
    check("R5 no early pulse", p, 0);
    release_scl(2);
    low_run(5, 0, p, f);
    check("R5 restart no pulse", p, 0);
    low_run(3, 0, p2, f2);
    check("R5 pulse at 6th", f2, 1);
    release_scl(2);
  endtask

  task automatic t_master();
    int p, f;
    wr_limit(8'd2);
    master_i = 1'b0;
    low_run(20, 0, p, f);
    check("R6 idle no pulse", p, 0);
    master_i = 1'b1;
    low_run(2, 0, p, f);
    check("R6 partial", p, 0);
    master_i = 1'b0;
    @(negedge clk_i);
    master_i = 1'b1;
    low_run(5, 0, p, f);
    check("R6 cleared by drop", f, 3);
    release_scl(2);
  endtask

  task automatic t_mid_write();
    int p, f;
    wr_limit(8'd9);
    low_run(2, 0, p, f);
    scl_i = 1'b0;
    wr_limit(8'd2);
    check("R8 written", limit_rdata_o, 2);
    low_run(10, 0, p, f);
    check("R8 old limit held", f, 8);
    check("R8 single", p, 1);
    release_scl(2);
    low_run(5, 0, p, f);
    check("R8 new limit next", f, 3);
    release_scl(2);
  endtask

  task automatic t_extremes();
    int p, f;
    wr_limit(8'd0);
    low_run(3, 0, p, f);
    check("R9 zero limit", f, 1);
    check("R9 zero single", p, 1);
    release_scl(2);
    wr_limit(8'hFF);
    low_run(255, 0, p, f);
    check("R9 max none at 255", p, 0);
    low_run(3, 0, p, f);
    check("R9 max at 256", f, 1);
    release_scl(2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write();
    t_basic();
    t_gaps();
    t_scl_high_clears();
    t_master();
    t_mid_write();
    t_extremes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule